// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command decoder of a NOR flash device. Every bus write gives it a command byte and an address. From these it tracks the device mode: the read source, a two-cycle block erase, erase suspension, and a program nested inside a suspended erase, which can itself be suspended. It holds the status byte. Its error bits stay set until software clears them.

Erase and program requests go out to an internal sequencer as one-cycle start pulses, together with a latched address and data byte. While an operation is suspended, level hold signals stay high. The sequencer reports back through a done strobe that carries a fail flag. A supply-valid input stands in for analog sensing of the programming voltage.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, `read_src` is 0 (array), and no start pulse or hold is asserted.
- R2: When no operation executes, command 0xFF sets `read_src` to 0 (array). Command 0x70 sets it to 1 (status), 0x90 sets it to 2 (configuration) and 0x98 sets it to 3 (query).
- R3: Erase takes two writes: 0x20, then 0xD0 with `supply_ok` high. In the cycle after the confirm write, `seq_erase_go` pulses for one cycle. `seq_addr` then holds the confirm-cycle address with its low `BLK_LSB` bits cleared. The setup-cycle address has no effect on it.
- R4: Status bit 7 is 0 while an erase or program executes, and 1 otherwise. While it is 0, `read_src` reads 1 (status).
- R5: If `supply_ok` is low at the confirm write, no erase starts, and status bits 5 and 3 are set.
- R6: If the write after 0x20 is anything other than 0xD0, no erase starts, and status bits 5 and 4 are set.
- R7: Command 0xB0 during an executing erase suspends it. This sets `seq_hold_erase` and status bit 6, and status bit 7 reads 1. Command 0xD0 then resumes the erase and clears both, without a new start pulse.
- R8: While an erase is suspended, only 0xFF, 0x70, 0x90, 0x98, 0x40 and 0xD0 are accepted. Every other byte, including 0x20, 0x50 and 0xB0, leaves the status byte, `read_src` and the sequencer outputs unchanged.
- R9: While an erase is suspended, 0x40 followed by a data write starts a program. `seq_prog_go` pulses, `seq_addr` takes the full data-cycle address and `seq_data` takes its byte. Status bit 7 reads 0 and bit 6 stays 1.
- R10: Command 0xB0 during the nested program suspends it. This sets `seq_hold_prog` and status bit 2, and `seq_hold_erase` stays high. Command 0xD0 resumes the program.
- R11: `seq_done` ends the executing operation. An erase returns to idle; a nested program returns to the erase-suspended state. With `seq_fail` high, an erase sets status bit 5 and a program sets bit 4. A done strobe wins over a 0xB0 written in the same cycle.
- R12: Status bits 5, 4 and 3 stay set until 0x50 is written in the idle state, which clears all three.
- R13: While an erase or program executes, every command except 0xB0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd | input | 8 | Command byte, or program data in the data cycle |
| wr_addr | input | ADDR_W | Bus write address |
| supply_ok | input | 1 | Programming supply within limits |
| seq_done | input | 1 | Sequencer finished the executing operation |
| seq_fail | input | 1 | Qualifies seq_done as a failure |
| read_src | output | 2 | Read source: 0 array, 1 status, 2 configuration, 3 query |
| status | output | 8 | Status byte |
| seq_erase_go | output | 1 | One-cycle erase start pulse |
| seq_prog_go | output | 1 | One-cycle program start pulse |
| seq_hold_erase | output | 1 | Erase is suspended |
| seq_hold_prog | output | 1 | Nested program is suspended |
| seq_addr | output | ADDR_W | Latched block or program address |
| seq_data | output | 8 | Latched program data |

## Verification
Every output comes straight from registers, so the result of a write or a done strobe is due exactly one clock edge after the cycle that carries it. Nothing depends combinationally on the inputs. The driver applies each stimulus at a falling edge and queues the expected output set just after the following rising edge. The monitor compares that set at the next falling edge, so every check lands in the single cycle where its effect first appears. For a stimulus that should be ignored, the bench uses the same one-cycle check and confirms that all outputs kept their previous values.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OPC_READ_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] OPC_READ_STATUS = 8'h70;
    localparam logic [CMD_W-1:0] OPC_READ_CONFIG = 8'h90;
    localparam logic [CMD_W-1:0] OPC_READ_QUERY  = 8'h98;
    localparam logic [CMD_W-1:0] OPC_CLEAR       = 8'h50;
    localparam logic [CMD_W-1:0] OPC_ERASE       = 8'h20;
    localparam logic [CMD_W-1:0] OPC_CONFIRM     = 8'hD0;
    localparam logic [CMD_W-1:0] OPC_SUSPEND     = 8'hB0;
    localparam logic [CMD_W-1:0] OPC_PROGRAM     = 8'h40;

    typedef enum logic [2:0] {
        OP_IDLE, OP_ESETUP, OP_EBUSY, OP_ESUSP, OP_PSETUP, OP_PBUSY, OP_PSUSP
    } op_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_CONFIG = 2'd2,
        SRC_QUERY  = 2'd3
    } src_e;

    typedef enum logic [3:0] {
        K_NONE, K_RD_ARRAY, K_RD_STATUS, K_RD_CONFIG, K_RD_QUERY,
        K_CLEAR, K_ERASE, K_CONFIRM, K_SUSPEND, K_PROGRAM
    } kind_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic supply_err;
    } err_t;

    function automatic kind_e classify(input logic [CMD_W-1:0] c);
        kind_e k;
        case (c)
            OPC_READ_ARRAY:  k = K_RD_ARRAY;
            OPC_READ_STATUS: k = K_RD_STATUS;
            OPC_READ_CONFIG: k = K_RD_CONFIG;
            OPC_READ_QUERY:  k = K_RD_QUERY;
            OPC_CLEAR:       k = K_CLEAR;
            OPC_ERASE:       k = K_ERASE;
            OPC_CONFIRM:     k = K_CONFIRM;
            OPC_SUSPEND:     k = K_SUSPEND;
            OPC_PROGRAM:     k = K_PROGRAM;
            default:         k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic src_e src_of(input kind_e k);
        src_e s;
        case (k)
            K_RD_STATUS: s = SRC_STATUS;
            K_RD_CONFIG: s = SRC_CONFIG;
            K_RD_QUERY:  s = SRC_QUERY;
            default:     s = SRC_ARRAY;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    output kind_e            kind,
    output logic             is_read_sel,
    output src_e             sel_src
);
    always_comb begin
        kind        = wr_en ? classify(wr_cmd) : K_NONE;
        is_read_sel = (kind == K_RD_ARRAY) || (kind == K_RD_STATUS) ||
                      (kind == K_RD_CONFIG) || (kind == K_RD_QUERY);
        sel_src     = src_of(kind);
    end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_t       set_err,
    input  logic       clr,
    input  logic       busy,
    input  logic       erase_held,
    input  logic       prog_held,
    output logic [7:0] status
);
    err_t err_q;

    always_ff @(posedge clk) begin
        if (rst)      err_q <= '0;
        else if (clr) err_q <= '0;
        else          err_q <= err_q | set_err;
    end

    assign status = {~busy, erase_held, err_q.erase_err, err_q.prog_err,
                     err_q.supply_err, prog_held, 2'b00};

    // R12: error bits survive every cycle without a clear
    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        $past(err_q.erase_err && !clr) |-> status[5]);

    // R12: a clear leaves no error bit standing
    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (status[5:3] == 3'b000));
endmodule

// File: rtl/fcmd_latch.sv
module fcmd_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BLK_LSB = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_cmd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              supply_ok,
    input  logic              seq_done,
    input  logic              seq_fail,
    output logic [1:0]        read_src,
    output logic [7:0]        status,
    output logic              seq_erase_go,
    output logic              seq_prog_go,
    output logic              seq_hold_erase,
    output logic              seq_hold_prog,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [7:0]        seq_data
);
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLK_LSB;

    op_e   op_q, op_n;
    src_e  mode_q, mode_n;
    kind_e kind;
    src_e  sel_src;
    logic  is_read_sel;
    logic  ego_n, pgo_n, ld_addr, ld_data, clr;
    logic  [ADDR_W-1:0] addr_d;
    err_t  set_err;
    logic  busy;

    fcmd_decode u_dec (
        .wr_en(wr_en), .wr_cmd(wr_cmd), .kind(kind),
        .is_read_sel(is_read_sel), .sel_src(sel_src)
    );

    always_comb begin
        op_n    = op_q;
        mode_n  = mode_q;
        ego_n   = 1'b0;
        pgo_n   = 1'b0;
        ld_addr = 1'b0;
        ld_data = 1'b0;
        addr_d  = wr_addr;
        set_err = '0;
        clr     = 1'b0;
        case (op_q)
            OP_IDLE: begin
                if (is_read_sel)         mode_n = sel_src;
                else if (kind == K_CLEAR) clr = 1'b1;
                else if (kind == K_ERASE) begin
                    op_n   = OP_ESETUP;
                    mode_n = SRC_STATUS;
                end
            end
            OP_ESETUP: begin
                if (wr_en) begin
                    mode_n = SRC_STATUS;
                    op_n   = OP_IDLE;
                    if (kind == K_CONFIRM && supply_ok) begin
                        op_n    = OP_EBUSY;
                        ego_n   = 1'b1;
                        ld_addr = 1'b1;
                        addr_d  = wr_addr & BLK_MASK;
                    end else if (kind == K_CONFIRM) begin
                        set_err.erase_err  = 1'b1;
                        set_err.supply_err = 1'b1;
                    end else begin
                        set_err.erase_err = 1'b1;
                        set_err.prog_err  = 1'b1;
                    end
                end
            end
            OP_EBUSY: begin
                if (seq_done) begin
                    op_n              = OP_IDLE;
                    set_err.erase_err = seq_fail;
                end else if (kind == K_SUSPEND) op_n = OP_ESUSP;
            end
            OP_ESUSP: begin
                if (is_read_sel)            mode_n = sel_src;
                else if (kind == K_PROGRAM) begin
                    op_n   = OP_PSETUP;
                    mode_n = SRC_STATUS;
                end else if (kind == K_CONFIRM) op_n = OP_EBUSY;
            end
            OP_PSETUP: begin
                if (wr_en) begin
                    op_n    = OP_PBUSY;
                    pgo_n   = 1'b1;
                    ld_addr = 1'b1;
                    ld_data = 1'b1;
                end
            end
            OP_PBUSY: begin
                if (seq_done) begin
                    op_n             = OP_ESUSP;
                    set_err.prog_err = seq_fail;
                end else if (kind == K_SUSPEND) op_n = OP_PSUSP;
            end
            OP_PSUSP: begin
                if (is_read_sel)            mode_n = sel_src;
                else if (kind == K_CONFIRM) op_n = OP_PBUSY;
            end
            default: op_n = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q         <= OP_IDLE;
            mode_q       <= SRC_ARRAY;
            seq_erase_go <= 1'b0;
            seq_prog_go  <= 1'b0;
        end else begin
            op_q         <= op_n;
            mode_q       <= mode_n;
            seq_erase_go <= ego_n;
            seq_prog_go  <= pgo_n;
        end
    end

    assign busy           = (op_q == OP_EBUSY) || (op_q == OP_PBUSY);
    assign seq_hold_erase = (op_q == OP_ESUSP) || (op_q == OP_PSETUP) ||
                            (op_q == OP_PBUSY) || (op_q == OP_PSUSP);
    assign seq_hold_prog  = (op_q == OP_PSUSP);
    assign read_src       = busy ? SRC_STATUS : mode_q;

    fcmd_status u_stat (
        .clk(clk), .rst(rst), .set_err(set_err), .clr(clr), .busy(busy),
        .erase_held(seq_hold_erase), .prog_held(seq_hold_prog), .status(status)
    );

    fcmd_latch #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .load(ld_addr), .d(addr_d), .q(seq_addr)
    );

    fcmd_latch #(.W(CMD_W)) u_data (
        .clk(clk), .rst(rst), .load(ld_data), .d(wr_cmd), .q(seq_data)
    );

    // R4: an executing operation forces status reads
    p_busy_src_r4: assert property (@(posedge clk) disable iff (rst)
        !status[7] |-> read_src == SRC_STATUS);

    // R3: an erase start coincides with the not-ready status
    p_ego_busy_r3: assert property (@(posedge clk) disable iff (rst)
        seq_erase_go |-> !status[7] && !status[6]);

    // R3: the erase start is a single-cycle pulse
    p_ego_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        seq_erase_go |=> !seq_erase_go);

    // R9: a program start only ever happens under a suspended erase
    p_pgo_nested_r9: assert property (@(posedge clk) disable iff (rst)
        seq_prog_go |-> status[6] && !status[7]);

    // R10: program suspension nests inside erase suspension
    p_hold_nest_r10: assert property (@(posedge clk) disable iff (rst)
        seq_hold_prog |-> seq_hold_erase && status[2] && status[7]);

    // R7: leaving erase suspension always resumes the erase
    p_resume_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(seq_hold_erase) |-> !status[7] && !status[6]);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
    localparam int AW = 20;

    typedef struct packed {
        logic [7:0]    st;
        logic [1:0]    src;
        logic          eg;
        logic          pg;
        logic          he;
        logic          hp;
        logic          ca;
        logic [AW-1:0] ad;
        logic          cd;
        logic [7:0]    dt;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_cmd = 8'h00;
    logic [AW-1:0] wr_addr = '0;
    logic supply_ok = 1'b1;
    logic seq_done = 1'b0;
    logic seq_fail = 1'b0;
    logic [1:0] read_src;
    logic [7:0] status;
    logic seq_erase_go, seq_prog_go, seq_hold_erase, seq_hold_prog;
    logic [AW-1:0] seq_addr;
    logic [7:0] seq_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .BLK_LSB(12)) u_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_addr(wr_addr),
        .supply_ok(supply_ok), .seq_done(seq_done), .seq_fail(seq_fail),
        .read_src(read_src), .status(status), .seq_erase_go(seq_erase_go),
        .seq_prog_go(seq_prog_go), .seq_hold_erase(seq_hold_erase),
        .seq_hold_prog(seq_hold_prog), .seq_addr(seq_addr), .seq_data(seq_data)
    );

    function automatic exp_t mk(input logic [7:0] st, input logic [1:0] src,
                                input logic eg, input logic pg,
                                input logic he, input logic hp);
        exp_t e;
        e = '0;
        e.st = st; e.src = src; e.eg = eg; e.pg = pg; e.he = he; e.hp = hp;
        return e;
    endfunction

    function automatic exp_t with_addr(input exp_t e0, input logic [AW-1:0] a);
        exp_t e;
        e = e0; e.ca = 1'b1; e.ad = a;
        return e;
    endfunction

    function automatic exp_t with_data(input exp_t e0, input logic [7:0] d);
        exp_t e;
        e = e0; e.cd = 1'b1; e.dt = d;
        return e;
    endfunction

    task automatic drv(input logic we, input logic [7:0] c, input logic [AW-1:0] a,
                       input logic sup, input logic dn, input logic fl,
                       input exp_t e, input string tag);
        @(negedge clk);
        wr_en = we; wr_cmd = c; wr_addr = a;
        supply_ok = sup; seq_done = dn; seq_fail = fl;
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [7:0] c, input logic [AW-1:0] a,
                      input exp_t e, input string tag);
        drv(1'b1, c, a, 1'b1, 1'b0, 1'b0, e, tag);
    endtask

    task automatic tick(input logic dn, input logic fl, input exp_t e, input string tag);
        drv(1'b0, 8'h00, '0, 1'b1, dn, fl, e, tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            logic  ok;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            ok = (status == e.st) && (read_src == e.src) && (seq_erase_go == e.eg) &&
                 (seq_prog_go == e.pg) && (seq_hold_erase == e.he) &&
                 (seq_hold_prog == e.hp) && (!e.ca || seq_addr == e.ad) &&
                 (!e.cd || seq_data == e.dt);
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s: got st=%h src=%0d eg=%b pg=%b he=%b hp=%b ad=%h dt=%h exp st=%h src=%0d eg=%b pg=%b he=%b hp=%b ad=%h dt=%h",
                         t, status, read_src, seq_erase_go, seq_prog_go, seq_hold_erase,
                         seq_hold_prog, seq_addr, seq_data, e.st, e.src, e.eg, e.pg,
                         e.he, e.hp, e.ad, e.dt);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        tick(0, 0, mk(8'h80, 2'd0, 0, 0, 0, 0), "R1 reset");
        // R2 read-source selection
        wr(8'h70, '0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R2 status sel");
        wr(8'h90, '0, mk(8'h80, 2'd2, 0, 0, 0, 0), "R2 config sel");
        wr(8'h98, '0, mk(8'h80, 2'd3, 0, 0, 0, 0), "R2 query sel");
        wr(8'hFF, '0, mk(8'h80, 2'd0, 0, 0, 0, 0), "R2 array sel");
        // R3 two-cycle erase, address latched at confirm
        wr(8'h20, 20'h11000, mk(8'h80, 2'd1, 0, 0, 0, 0), "R3 setup");
        wr(8'hD0, 20'h2A345, with_addr(mk(8'h00, 2'd1, 1, 0, 0, 0), 20'h2A000), "R3 confirm");
        tick(0, 0, with_addr(mk(8'h00, 2'd1, 0, 0, 0, 0), 20'h2A000), "R4 busy");
        // R13 read-mode change ignored while busy
        wr(8'hFF, '0, mk(8'h00, 2'd1, 0, 0, 0, 0), "R13 ignore busy");
        // R7 erase suspend
        wr(8'hB0, '0, mk(8'hC0, 2'd1, 0, 0, 1, 0), "R7 suspend");
        // R8 erase setup ignored while suspended
        wr(8'h20, 20'h55000, mk(8'hC0, 2'd1, 0, 0, 1, 0), "R8 erase ignored");
        wr(8'hFF, '0, mk(8'hC0, 2'd0, 0, 0, 1, 0), "R8 array allowed");
        // R9 nested program
        wr(8'h40, '0, mk(8'hC0, 2'd1, 0, 0, 1, 0), "R9 prog setup");
        wr(8'h5A, 20'h00123, with_data(with_addr(mk(8'h40, 2'd1, 0, 1, 1, 0), 20'h00123), 8'h5A), "R9 prog start");
        // R10 program suspend inside erase suspend
        wr(8'hB0, '0, mk(8'hC4, 2'd1, 0, 0, 1, 1), "R10 prog suspend");
        wr(8'h20, '0, mk(8'hC4, 2'd1, 0, 0, 1, 1), "R8 ignore in nested");
        wr(8'hD0, '0, with_addr(mk(8'h40, 2'd1, 0, 0, 1, 0), 20'h00123), "R10 prog resume");
        // R11 program failure returns to erase suspended
        tick(1, 1, mk(8'hD0, 2'd1, 0, 0, 1, 0), "R11 prog fail");
        // R8 clear ignored while suspended
        wr(8'h50, '0, mk(8'hD0, 2'd1, 0, 0, 1, 0), "R8 clear ignored");
        wr(8'hB0, '0, mk(8'hD0, 2'd1, 0, 0, 1, 0), "R8 suspend ignored");
        // R7 erase resume
        wr(8'hD0, '0, with_addr(mk(8'h10, 2'd1, 0, 0, 0, 0), 20'h00123), "R7 resume");
        tick(1, 0, mk(8'h90, 2'd1, 0, 0, 0, 0), "R11 erase done");
        // R12 sticky until clear
        wr(8'h70, '0, mk(8'h90, 2'd1, 0, 0, 0, 0), "R12 sticky");
        wr(8'h50, '0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R12 clear");
        // R5 supply fault at confirm
        wr(8'h20, 20'h03000, mk(8'h80, 2'd1, 0, 0, 0, 0), "R5 setup");
        drv(1'b1, 8'hD0, 20'h03000, 1'b0, 1'b0, 1'b0, mk(8'hA8, 2'd1, 0, 0, 0, 0), "R5 supply fault");
        wr(8'h50, '0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R12 clear supply");
        // R6 bad sequence
        wr(8'h20, 20'h03000, mk(8'h80, 2'd1, 0, 0, 0, 0), "R6 setup");
        wr(8'hFF, 20'h03000, mk(8'hB0, 2'd1, 0, 0, 0, 0), "R6 sequence error");
        wr(8'h50, '0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R12 clear sequence");
        // R11 done wins over a same-cycle suspend
        wr(8'h20, '0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R11 setup");
        wr(8'hD0, 20'hFFFFF, with_addr(mk(8'h00, 2'd1, 1, 0, 0, 0), 20'hFF000), "R3 confirm high block");
        drv(1'b1, 8'hB0, '0, 1'b1, 1'b1, 1'b0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R11 done beats suspend");
        // R11 erase failure
        wr(8'h20, '0, mk(8'h80, 2'd1, 0, 0, 0, 0), "R11 setup2");
        wr(8'hD0, 20'h04000, with_addr(mk(8'h00, 2'd1, 1, 0, 0, 0), 20'h04000), "R3 confirm2");
        tick(1, 1, mk(8'hA0, 2'd1, 0, 0, 0, 0), "R11 erase fail");
        wr(8'hFF, '0, mk(8'hA0, 2'd0, 0, 0, 0, 0), "R12 sticky after read sel");
        wr(8'h50, '0, mk(8'h80, 2'd0, 0, 0, 0, 0), "R12 final clear");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule